// File: doc/BRIEF.md
# SPI Wiper Register Slave for a Digital Potentiometer

This block models the digital side of a one- or two-channel digital potentiometer. It is an SPI slave in mode 0 whose only state is one 9-bit position register per wiper. A controller sends a 16-bit frame, most significant bit first, with chip select held low.

The first byte of the frame holds three fields:
- bits 7:4 are the register address (wiper 0 is address 0, wiper 1 is address 1);
- bits 3:2 are the operation code;
- bits 1:0 are data bits 9:8.

The second byte holds data bits 7:0. While the header is still arriving, the slave tells the controller on MISO whether the address and operation pair is legal. On a read, it shifts the addressed position back out.

The SPI pins are sampled with the block's own clock. The positions are brought out in parallel so that a surrounding model or a testbench can observe them. Two parameters select the configuration: the number of wipers (1 or 2) and the full-scale count (128 or 256).

Top module: `pot_spi_wiper`

## Requirements
- R1: After reset every wiper holds half the full-scale count (128 for a 256-step part, 64 for a 128-step part).
- R2: Operation code 00 at a legal address stores the 10-bit data field {first byte bits 1:0, second byte} into that wiper on the 16th rising SCLK edge. The other wiper keeps its value.
- R3: Operation code 11 at a legal address returns the low 8 bits of the wiper as the second reply byte, MSB first, and changes no wiper.
- R4: The first reply byte has bits 7:2 at 1. Bit 1 is 1 for a legal header and 0 otherwise. Bit 0 is bit 8 of the addressed wiper when the header is legal and 0 otherwise. A wiper at 256 therefore reads back as first byte 0xFF and second byte 0x00.
- R5: A write whose data field exceeds the full-scale count stores the full-scale count.
- R6: A header is legal only when the address is below the wiper count and the code is 00 or 11. An illegal header changes no wiper, and its second reply byte is 0xFF.
- R7: A frame ended by chip select rising before the 16th rising SCLK edge changes no wiper.
- R8: MISO is driven high whenever chip select is high.
- R9: No wiper ever holds a value above the full-scale count.
- R10: MOSI is sampled on rising SCLK edges, and MISO changes only after falling SCLK edges or when chip select is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the SPI pins |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial reply to the controller |
| wiper_pos | output | WIPERS*9 | Wiper positions; wiper k occupies bits 9k+8:9k |

## Verification
Two instances are exercised: one with two wipers and 256 steps, one with a single wiper and 128 steps.

- Writes followed by reads of both wipers show whether the address selects the right register and leaves the other untouched.
- Writes of exactly full scale, above full scale, and zero separate correct bit-8 encoding in the reply from saturation.
- Headers with the two unsupported codes, with an address past the last wiper, or with wiper 1 on the single-wiper part should raise no legal flag and change nothing.
- Frames cut off after 10 and after 15 clocks must leave the positions intact, while the following full frame must take effect.

// File: rtl/pot_pkg.sv
package pot_pkg;

  localparam int ADDR_W     = 4;
  localparam int CODE_W     = 2;
  localparam int POS_W      = 9;
  localparam int DATA_W     = 10;
  localparam int FRAME_BITS = 16;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int HDR_BITS   = ADDR_W + CODE_W;

  localparam logic [CODE_W-1:0] CODE_WRITE = 2'b00;
  localparam logic [CODE_W-1:0] CODE_READ  = 2'b11;

  // Reply slots, counted as rising edges already seen when the bit is driven
  localparam logic [CNT_W-1:0] SLOT_FLAG = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] SLOT_MSB  = CNT_W'(HDR_BITS + 1);
  localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(FRAME_BITS - 1);

  typedef logic [POS_W-1:0] pos_t;

  // Legal address/code pair for a part with nw wipers
  function automatic logic hdr_legal(logic [ADDR_W-1:0] addr,
                                     logic [CODE_W-1:0] code,
                                     int unsigned nw);
    return (32'(addr) < nw) && (code == CODE_WRITE || code == CODE_READ);
  endfunction

  // Saturate a 10-bit data field at the full-scale count
  function automatic pos_t clamp_pos(logic [DATA_W-1:0] raw, int unsigned fs);
    if (32'(raw) > fs) return POS_W'(fs);
    return raw[POS_W-1:0];
  endfunction

  // Serial reply bit driven after n rising edges of the frame
  function automatic logic reply_bit(logic [CNT_W-1:0] n, logic ok,
                                     logic rd, pos_t pos);
    logic [3:0] idx;
    idx = 4'd15 - n[3:0];
    if (n < SLOT_FLAG) return 1'b1;
    if (n == SLOT_FLAG) return ok;
    if (n == SLOT_MSB) return ok & pos[POS_W-1];
    if (n <= SLOT_LAST) return (ok & rd) ? pos[idx[2:0]] : 1'b1;
    return 1'b1;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_pin,
  input  logic cs_n_pin,
  input  logic mosi_pin,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_active,
  output logic mosi_s
);
  logic [STAGES-1:0] sclk_sh, csn_sh, mosi_sh;
  logic sclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_sh <= '0;
      csn_sh  <= '1;
      mosi_sh <= '0;
      sclk_d  <= 1'b0;
    end else begin
      sclk_sh <= {sclk_sh[STAGES-2:0], sclk_pin};
      csn_sh  <= {csn_sh[STAGES-2:0], cs_n_pin};
      mosi_sh <= {mosi_sh[STAGES-2:0], mosi_pin};
      sclk_d  <= sclk_sh[STAGES-1];
    end
  end

  assign sclk_rise = sclk_sh[STAGES-1] & ~sclk_d;
  assign sclk_fall = ~sclk_sh[STAGES-1] & sclk_d;
  assign cs_active = ~csn_sh[STAGES-1];
  assign mosi_s    = mosi_sh[STAGES-1];
endmodule

// File: rtl/pot_frame_ctrl.sv
module pot_frame_ctrl
  import pot_pkg::*;
#(
  parameter int WIPERS     = 2,
  parameter int FULL_SCALE = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_active,
  input  logic              mosi_s,
  input  pos_t              rd_pos,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              hdr_done,
  output logic              wr_commit,
  output pos_t              wr_data,
  output logic              miso
);
  localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);

  logic [POS_W-1:0]    shreg;
  logic [HDR_BITS-1:0] hdr;
  logic                ok_q, rd_q;

  assign hdr       = {shreg[HDR_BITS-2:0], mosi_s};
  assign hdr_done  = sclk_rise & cs_active & (bit_cnt == LAST_HDR);
  assign wr_commit = sclk_rise & cs_active & (bit_cnt == SLOT_LAST) & ok_q & ~rd_q;
  assign wr_data   = clamp_pos({shreg, mosi_s}, FULL_SCALE);

  always_ff @(posedge clk) begin
    if (!rst_n || !cs_active) begin
      shreg   <= '0;
      bit_cnt <= '0;
      addr_q  <= '0;
      ok_q    <= 1'b0;
      rd_q    <= 1'b0;
      miso    <= 1'b1;
    end else begin
      if (sclk_rise && bit_cnt < FULL_CNT) begin
        shreg   <= {shreg[POS_W-2:0], mosi_s};
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (hdr_done) begin
        addr_q <= hdr[HDR_BITS-1:CODE_W];
        ok_q   <= hdr_legal(hdr[HDR_BITS-1:CODE_W], hdr[CODE_W-1:0], WIPERS);
        rd_q   <= (hdr[CODE_W-1:0] == CODE_READ);
      end
      if (sclk_fall) miso <= reply_bit(bit_cnt, ok_q, rd_q, rd_pos);
    end
  end
endmodule

// File: rtl/pot_wiper_bank.sv
module pot_wiper_bank
  import pot_pkg::*;
#(
  parameter int WIPERS     = 2,
  parameter int FULL_SCALE = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  pos_t                    wr_data,
  output pos_t                    rd_pos,
  output logic [WIPERS*POS_W-1:0] wiper_pos
);
  localparam pos_t MID = POS_W'(FULL_SCALE / 2);

  pos_t regs [WIPERS];

  for (genvar g = 0; g < WIPERS; g++) begin : g_wiper
    always_ff @(posedge clk) begin
      if (!rst_n)                               regs[g] <= MID;
      else if (wr_en && addr == ADDR_W'(g))     regs[g] <= wr_data;
    end
    assign wiper_pos[g*POS_W +: POS_W] = regs[g];
  end

  always_comb begin
    rd_pos = '0;
    for (int k = 0; k < WIPERS; k++)
      if (addr == ADDR_W'(k)) rd_pos = regs[k];
  end
endmodule

// File: rtl/pot_spi_wiper.sv
module pot_spi_wiper
  import pot_pkg::*;
#(
  parameter int WIPERS     = 2,
  parameter int FULL_SCALE = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spi_sclk,
  input  logic                    spi_cs_n,
  input  logic                    spi_mosi,
  output logic                    spi_miso,
  output logic [WIPERS*POS_W-1:0] wiper_pos
);
  logic              sclk_rise, sclk_fall, cs_active, mosi_s;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic              hdr_done, wr_commit;
  pos_t              wr_data, rd_pos;

  spi_pin_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sclk_pin(spi_sclk), .cs_n_pin(spi_cs_n), .mosi_pin(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_active(cs_active), .mosi_s(mosi_s)
  );

  pot_frame_ctrl #(.WIPERS(WIPERS), .FULL_SCALE(FULL_SCALE)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_active(cs_active), .mosi_s(mosi_s), .rd_pos(rd_pos),
    .addr_q(addr_q), .bit_cnt(bit_cnt), .hdr_done(hdr_done),
    .wr_commit(wr_commit), .wr_data(wr_data), .miso(spi_miso)
  );

  pot_wiper_bank #(.WIPERS(WIPERS), .FULL_SCALE(FULL_SCALE)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_commit), .addr(addr_q),
    .wr_data(wr_data), .rd_pos(rd_pos), .wiper_pos(wiper_pos)
  );
endmodule

// File: rtl/pot_spi_wiper_chk.sv
module pot_spi_wiper_chk
  import pot_pkg::*;
#(
  parameter int WIPERS     = 2,
  parameter int FULL_SCALE = 256
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cs_active,
  input logic                    sclk_fall,
  input logic                    hdr_done,
  input logic                    wr_commit,
  input logic [CNT_W-1:0]        bit_cnt,
  input logic                    spi_miso,
  input logic [WIPERS*POS_W-1:0] wiper_pos
);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(FRAME_BITS - 1);

  for (genvar g = 0; g < WIPERS; g++) begin : g_range
    assert_pos_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      32'(wiper_pos[g*POS_W +: POS_W]) <= FULL_SCALE);
  end

  assert_hold_without_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(wiper_pos));

  assert_commit_on_last_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> cs_active && bit_cnt == LAST_EDGE);

  assert_header_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done |-> cs_active);

  assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> spi_miso);

  assert_miso_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_miso) |-> $past(sclk_fall) || !$past(cs_active));
endmodule

bind pot_spi_wiper pot_spi_wiper_chk #(.WIPERS(WIPERS), .FULL_SCALE(FULL_SCALE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .sclk_fall(sclk_fall),
  .hdr_done(hdr_done), .wr_commit(wr_commit), .bit_cnt(bit_cnt),
  .spi_miso(spi_miso), .wiper_pos(wiper_pos)
);

// File: tb/tb_pot_spi_wiper.sv
module tb_pot_spi_wiper;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, cs0 = 1'b1, cs1 = 1'b1;
  logic miso0, miso1;
  logic [17:0] wp_big;
  logic [8:0]  wp_small;

  always #5 clk = ~clk;

  pot_spi_wiper #(.WIPERS(2), .FULL_SCALE(256)) dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs0),
    .spi_mosi(mosi), .spi_miso(miso0), .wiper_pos(wp_big));

  pot_spi_wiper #(.WIPERS(1), .FULL_SCALE(128)) dut_small (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs1),
    .spi_mosi(mosi), .spi_miso(miso1), .wiper_pos(wp_small));

  int checks = 0, errors = 0;

  typedef struct { logic [15:0] word; string req; } exp_t;
  exp_t        sb_q[$];
  logic [15:0] got_word;
  event        frame_ev;

  logic [8:0] m_w [2][2];
  int m_nw [2] = '{2, 1};
  int m_fs [2] = '{256, 128};

  task automatic note(string req, logic good, int act, int expv);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  // Driver: predicts the reply, pushes it, then shifts the frame
  task automatic spi_frame(int d, logic [7:0] b0, logic [7:0] b1, int nbits, string req);
    logic [15:0] tx, rx;
    logic [3:0]  a;
    logic [1:0]  c;
    logic        ok, rd;
    int          ai;
    logic [9:0]  val;
    exp_t        e;
    tx = {b0, b1};
    rx = '1;
    a  = b0[7:4];
    c  = b0[3:2];
    ok = (int'(a) < m_nw[d]) && (c == 2'b00 || c == 2'b11);
    rd = (c == 2'b11);
    ai = ok ? int'(a) : 0;
    e.req  = req;
    e.word = {6'h3F, ok, ok ? m_w[d][ai][8] : 1'b0,
              (ok && rd) ? m_w[d][ai][7:0] : 8'hFF};
    if (nbits == 16) sb_q.push_back(e);
    if (d == 0) cs0 = 1'b0; else cs1 = 1'b0;
    wait_half();
    for (int i = 15; i > 15 - nbits; i--) begin
      mosi = tx[i];
      wait_half();
      rx[i] = (d == 0) ? miso0 : miso1;
      sclk = 1'b1;
      wait_half();
      sclk = 1'b0;
    end
    wait_half();
    cs0 = 1'b1;
    cs1 = 1'b1;
    wait_half();
    if (nbits == 16) begin
      got_word = rx;
      -> frame_ev;
      if (ok && !rd) begin
        val = {b0[1:0], b1};
        m_w[d][ai] = (int'(val) > m_fs[d]) ? 9'(m_fs[d]) : val[8:0];
      end
    end
    wait_half();
  endtask

  // Monitor: pops the prediction and compares the captured reply
  initial begin
    exp_t e;
    forever begin
      @(frame_ev);
      if (sb_q.size() == 0) note("scoreboard empty R4", 1'b0, 0, 1);
      else begin
        e = sb_q.pop_front();
        note({e.req, " first reply byte R4 R10"}, got_word[15:8] == e.word[15:8],
             int'(got_word[15:8]), int'(e.word[15:8]));
        note({e.req, " second reply byte"}, got_word[7:0] == e.word[7:0],
             int'(got_word[7:0]), int'(e.word[7:0]));
      end
    end
  end

  task automatic check_wipers(string req);
    for (int i = 0; i < 2; i++)
      note({req, " big wiper"}, wp_big[i*9 +: 9] == m_w[0][i],
           int'(wp_big[i*9 +: 9]), int'(m_w[0][i]));
    note({req, " small wiper"}, wp_small == m_w[1][0], int'(wp_small), int'(m_w[1][0]));
  endtask

  task automatic check_idle();
    note("R8 MISO high with chip select released", miso0 === 1'b1 && miso1 === 1'b1,
         int'({miso0, miso1}), 3);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired R1 actual 1 expected 0");
    finish_run();
  end

  initial begin
    m_w[0][0] = 9'd128; m_w[0][1] = 9'd128;
    m_w[1][0] = 9'd64;  m_w[1][1] = 9'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_wipers("R1 reset mid-scale");
    check_idle();

    // R2 writes to each wiper
    spi_frame(0, 8'h00, 8'h25, 16, "R2 write w0");
    check_wipers("R2 write w0=37");
    spi_frame(0, 8'h10, 8'hC8, 16, "R2 write w1");
    check_wipers("R2 write w1=200, w0 kept");
    check_idle();

    // R3 read-back
    spi_frame(0, 8'h0C, 8'h00, 16, "R3 read w0");
    spi_frame(0, 8'h1C, 8'h00, 16, "R3 read w1");
    check_wipers("R3 read leaves wipers");

    // R4 full-scale encoding
    spi_frame(0, 8'h01, 8'h00, 16, "R4 write 256");
    spi_frame(0, 8'h0C, 8'h00, 16, "R4 read 256");
    check_wipers("R4 w0 at 256");

    // R5 saturation
    spi_frame(0, 8'h13, 8'hFF, 16, "R5 write 1023");
    check_wipers("R5 clamp to 256");
    spi_frame(1, 8'h00, 8'hC8, 16, "R5 small write 200");
    check_wipers("R5 small clamp to 128");
    spi_frame(1, 8'h0C, 8'h00, 16, "R5 small read");
    spi_frame(1, 8'h01, 8'h01, 16, "R5 small write 257");
    check_wipers("R5 small clamp from 257");

    // R6 illegal headers
    spi_frame(0, 8'h05, 8'h11, 16, "R6 code 01");
    spi_frame(0, 8'h09, 8'h22, 16, "R6 code 10");
    spi_frame(0, 8'h50, 8'h33, 16, "R6 address 5");
    spi_frame(1, 8'h10, 8'h05, 16, "R6 small address 1");
    spi_frame(1, 8'h1C, 8'h00, 16, "R6 small read address 1");
    check_wipers("R6 illegal frames change nothing");

    // R7 truncated frames
    spi_frame(0, 8'h00, 8'h09, 10, "R7 cut at 10");
    check_wipers("R7 cut at 10 keeps wipers");
    spi_frame(0, 8'h10, 8'h09, 15, "R7 cut at 15");
    check_wipers("R7 cut at 15 keeps wipers");
    check_idle();
    spi_frame(0, 8'h10, 8'h09, 16, "R2 full frame after cut");
    check_wipers("R2 w1=9 after cut frames");

    // Zero boundary
    spi_frame(0, 8'h00, 8'h00, 16, "R2 write 0");
    spi_frame(0, 8'h0C, 8'hFF, 16, "R3 read 0");
    check_wipers("R2 w0=0");
    check_idle();

    repeat (20) @(negedge clk);
    note("R4 scoreboard drained", sb_q.size() == 0, sb_q.size(), 0);
    finish_run();
  end
endmodule